// File: doc/BRIEF.md
# Gated 13-bit timer/counter

This block is a 13-bit up-counter with a small control and status register. The count is held as an 8-bit high byte and a 5-bit low field. The low field works as a divide-by-32 stage whose carry steps the high byte. Software chooses the count source. The block counts either a one-cycle tick enable supplied from outside, or falling edges on an external count pin, which is synchronised with two flops.

Counting runs only while the run bit is set. When the gate bit is set, counting also requires the synchronised external gate pin to be high, so the count measures how long that pin stays high. When the count wraps from all ones to zero, the block raises an overflow flag. If the toggle enable is set, the wrap also inverts a dedicated output pin. The flag clears on an interrupt-acknowledge pulse or on a software write of zero.

Software reads and writes the block through a simple select/data port. The control byte uses bit 0 for run, bit 1 for gate, bit 2 for source (1 = external pin), bit 3 for toggle enable and bit 4 for the overflow flag. Bits 7:5 are reserved. Select code 0 addresses the control byte, 1 the low field and 2 the high byte. Code 3 reads as zero.

Top module: `gated_timer13`

## Requirements
- R1: After synchronous reset the control byte, both count registers, `ovf_o` and `tog_o` read as zero.
- R2: A write with select 1 loads the low field from data bits 4:0, and a write with select 2 loads the high byte. Reading select 1 returns the low field in bits 4:0 with bits 7:5 as zero. Reading select 2 returns the high byte.
- R3: With source 0 and counting enabled, each clock cycle with `tick_i` high adds one to the 13-bit value {high, low}. A low field of 31 carries into the high byte.
- R4: An increment from 0x1FFF gives 0x0000 and sets the overflow flag (control bit 4, `ovf_o`). No other increment sets it.
- R5: Counting is enabled only when run is 1 and either gate is 0 or the gate pin, after a two-flop synchroniser, is 1. With gate at 0 the pin has no effect.
- R6: While run is 0 the count holds. Setting run again resumes from the held value and does not clear it.
- R7: With source 1, each falling edge on `cnt_pin_i`, seen after a two-flop synchroniser, adds one. Rising edges and `tick_i` have no effect.
- R8: An `ack_i` pulse clears the flag. A control write with bit 4 at 0 clears it and with bit 4 at 1 sets it. A set in the same cycle as `ack_i` leaves the flag at 1.
- R9: When toggle enable (bit 3) is 1, `tog_o` inverts on each wrap. When it is 0, `tog_o` holds.
- R10: Control bits 7:5 always read as zero, even after a write of ones.
- R11: A count-register write in the same cycle as an increment takes effect, and the increment of that cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle internal count enable |
| cnt_pin_i | input | 1 | External count pin (asynchronous) |
| gate_pin_i | input | 1 | External gate pin (asynchronous) |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write select: 0 control, 1 low, 2 high |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 2 | Read select, same coding as writes |
| rd_data_o | output | 8 | Read data for the selected register |
| ack_i | input | 1 | Interrupt acknowledge, clears the flag |
| ovf_o | output | 1 | Overflow flag |
| tog_o | output | 1 | Output that toggles on wrap |

## Verification
The bench builds the block with its default widths: an 8-bit high byte and a 5-bit low field, two synchroniser stages. These widths keep the full 8192-value count range small enough to sweep. One tick at a time, it walks every count value from zero through the wrap, checking each value and the flag at the boundary. A second full lap checks that the toggle output returns to its start. Gating, counter mode with rising edges that must not count, and same-cycle write and acknowledge collisions are placed at exact cycles, with expected counts computed arithmetically.

// File: rtl/gt13_pkg.sv
package gt13_pkg;
    localparam int BYTE_W = 8;
    localparam int HI_W   = 8;
    localparam int LO_W   = 5;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_LOW  = 2'd1,
        SEL_HIGH = 2'd2
    } reg_sel_e;

    // Packed MSB first: flag is bit 4, run is bit 0
    typedef struct packed {
        logic flag;
        logic tog_en;
        logic src_ext;
        logic gate;
        logic run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic ctrl_t ctrl_from_byte(input logic [BYTE_W-1:0] b);
        return ctrl_t'(b[CTRL_W-1:0]);
    endfunction

    function automatic logic [BYTE_W-1:0] ctrl_to_byte(input ctrl_t c);
        return {{(BYTE_W-CTRL_W){1'b0}}, c};
    endfunction
endpackage

// File: rtl/gt13_sync.sv
module gt13_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic level_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= pin_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign level_o = chain_q[STAGES-1];
endmodule

// File: rtl/gt13_count_core.sv
module gt13_count_core
    import gt13_pkg::*;
#(
    parameter int HW = HI_W,
    parameter int LW = LO_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inc_i,
    input  logic              ld_lo_i,
    input  logic              ld_hi_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [HW+LW-1:0]  cnt_o,
    output logic              wrap_o
);
    logic [LW-1:0] lo_q;
    logic [HW-1:0] hi_q;
    logic          any_ld;
    logic          lo_carry;

    assign any_ld   = ld_lo_i | ld_hi_i;
    assign lo_carry = &lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (any_ld) begin
            if (ld_lo_i) lo_q <= wdata_i[LW-1:0];
            if (ld_hi_i) hi_q <= wdata_i[HW-1:0];
        end else if (inc_i) begin
            lo_q <= lo_q + 1'b1;
            if (lo_carry) hi_q <= hi_q + 1'b1;
        end
    end

    assign cnt_o  = {hi_q, lo_q};
    assign wrap_o = inc_i & ~any_ld & lo_carry & (&hi_q);
endmodule

// File: rtl/gated_timer13.sv
module gated_timer13
    import gt13_pkg::*;
#(
    parameter int HW          = HI_W,
    parameter int LW          = LO_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              cnt_pin_i,
    input  logic              gate_pin_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic [1:0]        rd_sel_i,
    output logic [BYTE_W-1:0] rd_data_o,
    input  logic              ack_i,
    output logic              ovf_o,
    output logic              tog_o
);
    localparam int CNT_W = HW + LW;

    ctrl_t             ctrl_q, ctrl_d, ctrl_wv;
    logic              gate_lvl, cnt_lvl, cnt_last_q, cnt_fall;
    logic              cnt_en, evt_w, inc_w, wrap_w;
    logic              wr_ctrl, ld_lo, ld_hi;
    logic              tog_q;
    logic [CNT_W-1:0]  cnt_w;

    gt13_sync #(.STAGES(SYNC_STAGES)) gate_sync_i (
        .clk(clk), .rst(rst), .pin_i(gate_pin_i), .level_o(gate_lvl)
    );

    gt13_sync #(.STAGES(SYNC_STAGES)) cnt_sync_i (
        .clk(clk), .rst(rst), .pin_i(cnt_pin_i), .level_o(cnt_lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) cnt_last_q <= 1'b0;
        else     cnt_last_q <= cnt_lvl;
    end

    assign cnt_fall = cnt_last_q & ~cnt_lvl;
    assign cnt_en   = ctrl_q.run & (~ctrl_q.gate | gate_lvl);
    assign evt_w    = ctrl_q.src_ext ? cnt_fall : tick_i;
    assign inc_w    = cnt_en & evt_w;

    assign wr_ctrl = wr_en_i && (wr_sel_i == SEL_CTRL);
    assign ld_lo   = wr_en_i && (wr_sel_i == SEL_LOW);
    assign ld_hi   = wr_en_i && (wr_sel_i == SEL_HIGH);

    gt13_count_core #(.HW(HW), .LW(LW)) core_i (
        .clk(clk), .rst(rst), .inc_i(inc_w),
        .ld_lo_i(ld_lo), .ld_hi_i(ld_hi), .wdata_i(wr_data_i),
        .cnt_o(cnt_w), .wrap_o(wrap_w)
    );

    // Later lines win: ack, then software write, then hardware wrap
    always_comb begin
        ctrl_wv = ctrl_from_byte(wr_data_i);
        ctrl_d  = wr_ctrl ? ctrl_wv : ctrl_q;
        ctrl_d.flag = ctrl_q.flag;
        if (ack_i)   ctrl_d.flag = 1'b0;
        if (wr_ctrl) ctrl_d.flag = ctrl_wv.flag;
        if (wrap_w)  ctrl_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            tog_q  <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
            if (wrap_w && ctrl_q.tog_en) tog_q <= ~tog_q;
        end
    end

    always_comb begin
        case (rd_sel_i)
            SEL_CTRL: rd_data_o = ctrl_to_byte(ctrl_q);
            SEL_LOW:  rd_data_o = BYTE_W'(cnt_w[LW-1:0]);
            SEL_HIGH: rd_data_o = BYTE_W'(cnt_w[CNT_W-1:LW]);
            default:  rd_data_o = '0;
        endcase
    end

    assign ovf_o = ctrl_q.flag;
    assign tog_o = tog_q;
endmodule

// File: rtl/gt13_checker.sv
module gt13_checker #(
    parameter int CNT_W = 13,
    parameter int LW    = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en_i,
    input logic [1:0]       wr_sel_i,
    input logic [7:0]       wr_data_i,
    input logic             ack_i,
    input logic             ovf_o,
    input logic             tog_o,
    input logic [CNT_W-1:0] cnt_q,
    input logic             inc,
    input logic             wrap,
    input logic             run
);
    logic cnt_wr, ctrl_set;
    assign cnt_wr   = wr_en_i && (wr_sel_i == 2'd1 || wr_sel_i == 2'd2);
    assign ctrl_set = wr_en_i && (wr_sel_i == 2'd0) && wr_data_i[4];

    a_r1_post_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!ovf_o && !tog_o && cnt_q == '0));

    a_r3_step: assert property (@(posedge clk) disable iff (rst)
        (inc && !cnt_wr) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

    a_r4_wrap_flag: assert property (@(posedge clk) disable iff (rst)
        wrap |=> ovf_o);

    a_r6_hold_stopped: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_wr) |=> $stable(cnt_q));

    a_r8_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !wrap && !ctrl_set) |=> !ovf_o);

    a_r9_tog_quiet: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(tog_o));

    a_r11_low_write_wins: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_sel_i == 2'd1) |=> cnt_q[LW-1:0] == $past(wr_data_i[LW-1:0]));
endmodule

bind gated_timer13 gt13_checker #(.CNT_W(HW+LW), .LW(LW)) chk_i (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .ack_i(ack_i), .ovf_o(ovf_o), .tog_o(tog_o),
    .cnt_q(cnt_w), .inc(inc_w), .wrap(wrap_w), .run(ctrl_q.run)
);

// File: tb/gated_timer13_tb_top.sv
module gated_timer13_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0, cnt_pin_i = 1'b1, gate_pin_i = 1'b0;
    logic       wr_en_i = 1'b0, ack_i = 1'b0;
    logic [1:0] wr_sel_i = 2'd0, rd_sel_i = 2'd0;
    logic [7:0] wr_data_i = 8'h00;
    logic [7:0] rd_data_o;
    logic       ovf_o, tog_o;

    int checks = 0;
    int errors = 0;
    int v, w;
    logic [7:0] d;

    always #(CLK_PERIOD/2) clk = ~clk;

    gated_timer13 dut_i (
        .clk(clk), .rst(rst), .tick_i(tick_i), .cnt_pin_i(cnt_pin_i),
        .gate_pin_i(gate_pin_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
        .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o),
        .ack_i(ack_i), .ovf_o(ovf_o), .tog_o(tog_o)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0h exp %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] dat);
        @(negedge clk);
        wr_en_i = 1'b1; wr_sel_i = s; wr_data_i = dat;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [7:0] dat);
        rd_sel_i = s;
        #1;
        dat = rd_data_o;
    endtask

    task automatic rd_cnt(output int val);
        logic [7:0] lo, hi;
        rd(2'd1, lo);
        rd(2'd2, hi);
        val = int'(hi) * 32 + int'(lo & 8'h1f);
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_i = 1'b1;
        repeat (n) @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        rd(2'd0, d); chk("R1 ctrl", d, 0);
        rd(2'd1, d); chk("R1 low", d, 0);
        rd(2'd2, d); chk("R1 high", d, 0);
        chk("R1 ovf", ovf_o, 0);
        chk("R1 tog", tog_o, 0);

        // R10 reserved bits, R2 count register access
        wr(2'd0, 8'hE0); rd(2'd0, d); chk("R10 reserved zero", d, 0);
        wr(2'd0, 8'hEE); rd(2'd0, d); chk("R10 fields", d, 8'h0E);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'hFF); rd(2'd1, d); chk("R2 low masked", d, 8'h1F);
        wr(2'd2, 8'hA5); rd(2'd2, d); chk("R2 high", d, 8'hA5);

        // R3/R4 full sweep, one tick at a time
        wr(2'd1, 8'h00); wr(2'd2, 8'h00);
        wr(2'd0, 8'h01);
        for (int k = 0; k < 8192; k++) begin
            ticks(1);
            rd_cnt(v);
            chk("R3 sweep", v, (k + 1) % 8192);
            if (k == 8190) chk("R4 no early flag", ovf_o, 0);
        end
        chk("R4 flag on wrap", ovf_o, 1);
        chk("R9 tog held when disabled", tog_o, 0);

        // R8 flag clearing and setting
        @(negedge clk); ack_i = 1'b1; @(negedge clk); ack_i = 1'b0;
        chk("R8 ack clears", ovf_o, 0);
        wr(2'd0, 8'h11); chk("R8 sw set", ovf_o, 1);
        wr(2'd0, 8'h01); chk("R8 sw clear", ovf_o, 0);
        @(negedge clk);
        wr_en_i = 1'b1; wr_sel_i = 2'd0; wr_data_i = 8'h11; ack_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0; ack_i = 1'b0;
        chk("R8 set beats ack", ovf_o, 1);
        wr(2'd0, 8'h01);

        // R6 stop and resume
        rd_cnt(w);
        wr(2'd0, 8'h00); ticks(20); rd_cnt(v);
        chk("R6 halted", v, w);
        wr(2'd2, 8'h12); wr(2'd1, 8'h03);
        wr(2'd0, 8'h01); rd_cnt(v); chk("R6 run keeps value", v, 12'h243);
        ticks(5); rd_cnt(v); chk("R6 resume", v, 12'h248);

        // R5 gating
        wr(2'd0, 8'h03); gate_pin_i = 1'b0; idle(4);
        ticks(10); rd_cnt(v); chk("R5 gate low blocks", v, 12'h248);
        gate_pin_i = 1'b1; idle(4);
        ticks(10); rd_cnt(v); chk("R5 gate high counts", v, 12'h252);
        gate_pin_i = 1'b0; wr(2'd0, 8'h01); idle(4);
        ticks(6); rd_cnt(v); chk("R5 gate bit off ignores pin", v, 12'h258);

        // R7 counter mode
        wr(2'd0, 8'h05); tick_i = 1'b1; idle(4);
        rd_cnt(w); chk("R7 tick ignored", w, 12'h258);
        for (int p = 0; p < 7; p++) begin
            cnt_pin_i = 1'b0; idle(3);
            cnt_pin_i = 1'b1; idle(3);
        end
        idle(3); rd_cnt(v); chk("R7 seven falls", v, w + 7);
        cnt_pin_i = 1'b0; idle(5); rd_cnt(v); chk("R7 fall counted", v, w + 8);
        cnt_pin_i = 1'b1; idle(5); rd_cnt(v); chk("R7 rise ignored", v, w + 8);
        tick_i = 1'b0;

        // R9 toggle output
        wr(2'd0, 8'h00);
        wr(2'd2, 8'hFF); wr(2'd1, 8'h1E);
        wr(2'd0, 8'h09);
        ticks(2); rd_cnt(v);
        chk("R9 wrap count", v, 0);
        chk("R9 toggled", tog_o, 1);
        chk("R4 flag again", ovf_o, 1);
        ticks(8192); rd_cnt(v);
        chk("R9 full lap count", v, 0);
        chk("R9 toggled back", tog_o, 0);
        wr(2'd0, 8'h00);
        wr(2'd2, 8'hFF); wr(2'd1, 8'h1F);
        wr(2'd0, 8'h01);
        ticks(1);
        chk("R9 disabled holds", tog_o, 0);
        chk("R4 flag disabled toggle", ovf_o, 1);

        // R11 write beats increment
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h30); wr(2'd1, 8'h00);
        wr(2'd0, 8'h01);
        @(negedge clk);
        tick_i = 1'b1; wr_en_i = 1'b1; wr_sel_i = 2'd1; wr_data_i = 8'h0A;
        @(negedge clk);
        tick_i = 1'b0; wr_en_i = 1'b0;
        rd_cnt(v); chk("R11 write wins", v, 8'h30 * 32 + 10);

        finish_run();
    end
endmodule